// File: doc/BRIEF.md
# SMBus Register Slave with Byte and Block Transfers

This block sits on a two-wire SMBus-style bus as a slave and exposes a small bank of 8-bit control registers to the bus host. It oversamples SCL and SDA with the system clock and recognises START and STOP conditions. It checks the 7-bit address, decodes the command code and acknowledges each accepted byte. During reads it shifts register contents out MSB first. SDA is open-drain: the block outputs only a pull-low enable, and it reads the resolved line back on a separate input.

Bit 7 of the command code chooses between two access types. When it is set, bits 6:0 name one register, and a single byte is written or read there. When it is clear, the access is a block transfer that starts at register 0. A block write carries a byte-count byte that the slave acknowledges but does not store. A block read first returns the number of registers and then streams the registers in ascending order for as long as the host acknowledges. Every register value is always visible on a flat parallel output, so the surrounding logic can use the registers as configuration.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset every register holds its power-up default, with register 0 in `regs_q[7:0]`, and `sda_oe` is 0.
- R2: The slave acknowledges an address byte whose upper seven bits equal `ADDR7` (default 7'h69: byte 8'hD2 for write, 8'hD3 for read). For any other address it drives no ACK, it ignores every byte up to the next START, and the registers are not changed.
- R3: Byte write: a command code with bit 7 = 1 names the register at offset bits 6:0, and the following data byte is stored there. The slave acknowledges the address, the command and the data byte.
- R4: Byte read: after a byte command, a repeated START and the read address, the slave returns the addressed register MSB first. The host ends the read with a NACK and a STOP.
- R5: Block write: a command code with bit 7 = 0 makes the next byte a byte count, which is acknowledged and not stored. The data bytes that follow are written to registers 0, 1, 2 and onwards, and each one is acknowledged.
- R6: Block read: after a block command, a repeated START and the read address, the slave returns the byte count `NREG` first and then the registers from offset 0 upward. It sends one more byte for every host ACK and stops after a host NACK.
- R7: A block transfer may end after any complete byte. A block write that stops early leaves the registers it did not reach unchanged. After a block read that ends early with a NACK, the slave releases SDA, and the next transaction works normally.
- R8: A write to an offset of `NREG` or higher is acknowledged and changes no register. A read from such an offset returns 8'h00.
- R9: A START in the middle of a byte drops that byte, and the next byte is taken as an address. A STOP in the middle of a byte drops that byte without writing it and returns the slave to idle.
- R10: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Resolved bus data line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_q | output | NREG*8 | All registers, register i in bits [i*8+7:i*8] |

## Verification
The bench targets the count byte in both directions. A design that stored the count would put it into register 0. A design that left the count out of a read would shift every returned byte down by one position. The bench ends block transfers early and checks the registers and the SDA line afterwards; a slave that kept driving SDA after the host's NACK would block the STOP that follows. It also sends a wrong address, an offset past the bank, and a START and a STOP in the middle of a byte. A slave that got these wrong would acknowledge bytes meant for another device, write outside its registers, or store a partial byte.

// File: rtl/smb_pkg.sv
package smb_pkg;
  // width of the register-offset field carried in a command code
  localparam int PTR_W = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} smb_state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_CMD, PH_DATA} smb_phase_t;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q      = pipe[STAGES-1];
  assign q_prev = pipe[STAGES];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter int              NREG = 8,
  parameter logic [NREG*8-1:0] INIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [PTR_W-1:0]  rd_addr,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_q
);
  localparam int AW = $clog2(NREG);
  localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(NREG);

  logic [7:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= INIT[i*8 +: 8];
    end else if (wr_en) begin
      mem[wr_addr[AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = ({1'b0, rd_addr} < LIMIT) ? mem[rd_addr[AW-1:0]] : 8'h00;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_q[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/smb_engine.sv
module smb_engine
  import smb_pkg::*;
#(
  parameter logic [6:0] ADDR7 = 7'h69,
  parameter int         NREG  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             sda_s,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] rd_addr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam logic [7:0]     CNT_BYTE = 8'(NREG);
  localparam logic [PTR_W:0] LIMIT    = (PTR_W+1)'(NREG);

  smb_state_t       st;
  smb_phase_t       ph;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg, txb;
  logic [PTR_W-1:0] ptr;
  logic             cnt_pend, rd_dir, mnak;
  logic [7:0]       tx_next;
  logic             ptr_in;

  assign tx_next = cnt_pend ? CNT_BYTE : rd_data;
  assign ptr_in  = ({1'b0, ptr} < LIMIT);
  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; ph <= PH_ADDR; bitcnt <= '0;
      shreg <= '0; txb <= '0; ptr <= '0;
      cnt_pend <= 1'b0; rd_dir <= 1'b0; mnak <= 1'b0;
      sda_oe <= 1'b0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        st <= ST_RX; ph <= PH_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
              if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (ph)
                PH_ADDR: begin
                  if (shreg[7:1] == ADDR7) begin
                    sda_oe <= 1'b1;
                    rd_dir <= shreg[0];
                    ph     <= shreg[0] ? PH_DATA : PH_CMD;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                PH_CMD: begin
                  sda_oe   <= 1'b1;
                  cnt_pend <= ~shreg[7];
                  ptr      <= shreg[7] ? shreg[6:0] : '0;
                  ph       <= PH_DATA;
                end
                default: begin
                  sda_oe <= 1'b1;
                  if (cnt_pend) begin
                    cnt_pend <= 1'b0;
                  end else begin
                    if (ptr_in) begin
                      wr_en   <= 1'b1;
                      wr_addr <= ptr;
                      wr_data <= shreg;
                    end
                    ptr <= ptr + 1'b1;
                  end
                end
              endcase
            end else if (scl_fall && bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (rd_dir) begin
                st     <= ST_TX;
                txb    <= tx_next;
                sda_oe <= ~tx_next[7];
                if (cnt_pend) cnt_pend <= 1'b0;
                else          ptr <= ptr + 1'b1;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              if (bitcnt == 4'd8) mnak <= sda_s;
              if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                txb    <= {txb[6:0], 1'b0};
                sda_oe <= ~txb[6];
              end else if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
              end else if (bitcnt == 4'd9) begin
                bitcnt <= '0;
                if (mnak) begin
                  st <= ST_IDLE;
                end else begin
                  txb    <= tx_next;
                  sda_oe <= ~tx_next[7];
                  if (cnt_pend) cnt_pend <= 1'b0;
                  else          ptr <= ptr + 1'b1;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter logic [6:0]        ADDR7       = 7'h69,
  parameter int                NREG        = 8,
  parameter logic [NREG*8-1:0] INIT        = 64'h1E2D3C4B00FFF6FF,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_q
);
  logic [1:0]       ln_s, ln_p;
  logic             scl_s, scl_p, sda_s, sda_p;
  logic             scl_rise, scl_fall, start_evt, stop_evt;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [7:0]       wr_data, rd_data;

  smb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(ln_s), .q_prev(ln_p)
  );

  assign {scl_s, sda_s} = ln_s;
  assign {scl_p, sda_p} = ln_p;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

  smb_engine #(.ADDR7(ADDR7), .NREG(NREG)) u_eng (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sda_oe(sda_oe)
  );

  smb_regfile #(.NREG(NREG), .INIT(INIT)) u_rf (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .regs_q(regs_q)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk
  import smb_pkg::*;
#(
  parameter int                NREG = 8,
  parameter logic [NREG*8-1:0] INIT = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              stop_evt,
  input logic              wr_en,
  input logic [PTR_W-1:0]  wr_addr,
  input logic [NREG*8-1:0] regs_q
);
  // R1: defaults present and bus released right after reset
  p_reset_defaults_r1: assert property (@(posedge clk)
    $past(rst) |-> (regs_q == INIT && !sda_oe));

  // R10: the slave begins pulling SDA low only while SCL is low
  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R9: a STOP condition releases the line
  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !sda_oe);

  // R8: the register write port is never used past the bank
  p_write_in_bank_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_addr} < (PTR_W+1)'(NREG)));

  // R2: registers change only through an accepted write
  p_regs_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs_q));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.NREG(NREG), .INIT(INIT)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .stop_evt(stop_evt), .wr_en(wr_en), .wr_addr(wr_addr), .regs_q(regs_q)
);

// File: tb/tb_smb_reg_slave.sv
module tb_smb_reg_slave;
  localparam int          NREG = 8;
  localparam logic [63:0] INIT = 64'h1E2D3C4B00FFF6FF;
  localparam int          Q    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_q;
  wire  sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  smb_reg_slave #(.NREG(NREG), .INIT(INIT)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_q(regs_q)
  );

  int    exp_q[$];
  string tag_q[$];
  int    obs_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  logic [7:0] model [NREG];

  function automatic void expect_item(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endfunction

  function automatic void observe(input int v);
    obs_q.push_back(v);
  endfunction

  // monitor: pops observed results and compares them with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        int o, e;
        string t;
        o = obs_q.pop_front();
        n_cmp++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected item: actual %0h expected none", o);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (o != e) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", t, o, e);
          end
        end
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    wait_clk(Q);
    scl_m = 1'b1; wait_clk(2*Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    b = sda_line; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic put_bits(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) put_bit(d[7-i]);
  endtask

  task automatic wbyte(input logic [7:0] d, input int exp_ack, input string tag);
    logic a;
    put_bits(d, 8);
    get_bit(a);
    expect_item(exp_ack, tag);
    observe(int'(a));
  endtask

  task automatic rbyte(input int exp, input logic nack, input string tag);
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      logic b;
      get_bit(b);
      d[7-i] = b;
    end
    put_bit(nack);
    expect_item(exp, tag);
    observe(int'(d));
  endtask

  task automatic chk_regs(input string tag);
    wait_clk(4);
    for (int i = 0; i < NREG; i++) begin
      expect_item(int'(model[i]), tag);
      observe(int'(regs_q[i*8 +: 8]));
    end
  endtask

  task automatic chk_released(input string tag);
    wait_clk(4);
    expect_item(0, tag);
    observe(int'(sda_oe));
  endtask

  task automatic byte_write(input int ofs, input logic [7:0] d, input string tag);
    bus_start();
    wbyte(8'hD2, 0, tag);
    wbyte(8'h80 | 8'(ofs), 0, tag);
    wbyte(d, 0, tag);
    bus_stop();
    if (ofs < NREG) model[ofs] = d;
  endtask

  task automatic byte_read(input int ofs, input string tag);
    bus_start();
    wbyte(8'hD2, 0, tag);
    wbyte(8'h80 | 8'(ofs), 0, tag);
    bus_start();
    wbyte(8'hD3, 0, tag);
    rbyte((ofs < NREG) ? int'(model[ofs]) : 0, 1'b1, tag);
    bus_stop();
  endtask

  task automatic block_write(input logic [7:0] cnt, input int k,
                             input logic [63:0] d, input string tag);
    bus_start();
    wbyte(8'hD2, 0, tag);
    wbyte(8'h00, 0, tag);
    wbyte(cnt, 0, tag);
    for (int i = 0; i < k; i++) begin
      wbyte(d[i*8 +: 8], 0, tag);
      model[i] = d[i*8 +: 8];
    end
    bus_stop();
  endtask

  task automatic block_read(input int k, input string tag);
    bus_start();
    wbyte(8'hD2, 0, tag);
    wbyte(8'h00, 0, tag);
    bus_start();
    wbyte(8'hD3, 0, tag);
    rbyte(NREG, (k == 0), tag);
    for (int i = 0; i < k; i++) rbyte(int'(model[i]), (i == k-1), tag);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = INIT[i*8 +: 8];
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);

    // R1: reset state
    chk_regs("R1");
    chk_released("R1");

    // R3 then R4: indexed write and read back, plus an untouched default
    byte_write(3, 8'h5A, "R3");
    chk_regs("R3");
    byte_read(3, "R4");
    byte_read(1, "R4");

    // R5: block write of four bytes after a count byte
    block_write(8'd4, 4, 64'h0000_0000_4433_2211, "R5");
    chk_regs("R5");

    // R6: full block read, count first then ascending registers
    block_read(NREG, "R6");

    // R7: early end of block write and block read
    block_write(8'd8, 1, 64'h0000_0000_0000_0099, "R7");
    chk_regs("R7");
    block_read(2, "R7");
    chk_released("R7");
    byte_read(5, "R7");

    // R2: foreign address is not acknowledged and changes nothing
    bus_start();
    wbyte(8'hA4, 1, "R2");
    wbyte(8'h82, 1, "R2");
    wbyte(8'hEE, 1, "R2");
    bus_stop();
    chk_regs("R2");

    // R8: offset past the bank
    byte_write(10, 8'h77, "R8");
    chk_regs("R8");
    byte_read(10, "R8");

    // R9: START in the middle of an address byte, then a normal write
    bus_start();
    put_bits(8'hD2, 4);
    bus_start();
    wbyte(8'hD2, 0, "R9");
    wbyte(8'h86, 0, "R9");
    wbyte(8'hC4, 0, "R9");
    bus_stop();
    model[6] = 8'hC4;
    chk_regs("R9");

    // R9: STOP in the middle of a data byte stores nothing
    bus_start();
    wbyte(8'hD2, 0, "R9");
    wbyte(8'h87, 0, "R9");
    put_bits(8'hA0, 3);
    bus_stop();
    chk_regs("R9");
    chk_released("R9");

    wait_clk(20);
    if (!done) begin
      done = 1'b1;
      if (exp_q.size() != 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule